// File: doc/BRIEF.md
# Cascaded Sticky Interrupt Aggregator

This block merges a set of level-sensitive serial interrupt lines into a single interrupt output through two stages of sticky status. The first stage turns each asserted line into a latched bit of a 32-bit status word. It ANDs that word with a mask. The result counts only while a global enable bit in a separate control register is set. The first-stage result feeds one bit of a read-only input word in the second stage. The second stage latches its masked input into its own sticky status, and the output interrupt is raised whenever that status is nonzero.

Software reaches both stages through a single 32-bit register port with a write strobe and a combinational read path. Both status words clear only through write-one-to-clear writes. The chain is evaluated on every clock, so a write to a mask, enable or status register takes effect at the next evaluation without any extra action. Some registers are held only for software use: two routing words, a polarity word, a firmware segment select and a firmware read-size word. They have no effect on the interrupt path.

Top module: `irq_cascade_agg`

## Requirements
- R1: After reset every register reads zero except the firmware read-size word at offset 0x04, which reads 0x02000000, and `irq_out` is low.
- R2: Serial line n (n = 0..16) sets bit 31−n of the first status word (offset 0x10) at the next clock edge; the bit stays set after the line falls.
- R3: Writing the first status word clears exactly the bits written as 1; if a line is asserted in the same cycle as a clear of its bit, the bit stays set.
- R4: The first-stage result is high only when bit 31 of the control word (offset 0x08) is set and (first status AND first mask at 0x0C) is nonzero; it is visible as bit 11 (value 0x800) of the read-only input word at offset 0x54.
- R5: Each clock the second status word (offset 0x48) gains input AND second mask (offset 0x4C); its bits stay set after the input falls and clear only by a write-one-to-clear write.
- R6: `irq_out` is high exactly when the second status word is nonzero.
- R7: The polarity word (0x50) and the routing words (0x40, 0x44) read back what was written and do not change `irq_out`.
- R8: Reads of offsets that decode to no register return 0xFFFFFFFF; writes to the error-address word (0x14) and to the input word are ignored.
- R9: A serial line that rises before clock edge k shows in the first status word after edge k and raises `irq_out` after edge k+1, given enable and both masks are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_irq | input | NUM_SER (17) | Level serial interrupt lines, index = IRQ number |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (8) | Byte offset of the register access |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Combinational read data for `addr` |
| irq_out | output | 1 | Aggregated interrupt |

## Verification
The bench goes after the bit reversal of the line mapping: a design that mapped line n to bit n would show 0x00010021 instead of 0x84008000 after lines 0, 5 and 16 pulse. It holds a line high in the same cycle as a clear of that bit; a clear-wins design would lose the bit. It clears the first stage after the second has latched, to catch a second stage that follows its input instead of holding it, and it counts the one-cycle gap between first-status set and `irq_out`, to catch a design that adds or drops a register. Polarity set to all ones must not change the output, and the error-address and input words must not take the data written to them.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   typedef enum logic [3:0] {
      RID_SEG,
      RID_RDSZ,
      RID_CTRL,
      RID_MASK1,
      RID_STAT1,
      RID_ERRA,
      RID_ROUTE0,
      RID_ROUTE1,
      RID_STAT2,
      RID_MASK2,
      RID_POL,
      RID_INPUT,
      RID_NONE
   } reg_id_e;

   localparam int OFS_SEG    = 'h00;
   localparam int OFS_RDSZ   = 'h04;
   localparam int OFS_CTRL   = 'h08;
   localparam int OFS_MASK1  = 'h0C;
   localparam int OFS_STAT1  = 'h10;
   localparam int OFS_ERRA   = 'h14;
   localparam int OFS_ROUTE0 = 'h40;
   localparam int OFS_ROUTE1 = 'h44;
   localparam int OFS_STAT2  = 'h48;
   localparam int OFS_MASK2  = 'h4C;
   localparam int OFS_POL    = 'h50;
   localparam int OFS_INPUT  = 'h54;

   localparam logic [31:0] RDSZ_RESET = 32'h0200_0000;

endpackage

// File: rtl/sticky_w1c_reg.sv
module sticky_w1c_reg #(
   parameter int W        = 32,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] set_vec,
   input  logic         clr_we,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] q
);

   logic [W-1:0] clr_eff;
   logic [W-1:0] q_r;

   assign clr_eff = clr_we ? clr_vec : '0;
   assign q       = q_r;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (SET_WINS) begin : g_setwin
         always_ff @(posedge clk) begin
            if (rst) q_r[i] <= 1'b0;
            else     q_r[i] <= set_vec[i] | (q_r[i] & ~clr_eff[i]);
         end
      end else begin : g_clrwin
         always_ff @(posedge clk) begin
            if (rst) q_r[i] <= 1'b0;
            else     q_r[i] <= (set_vec[i] | q_r[i]) & ~clr_eff[i];
         end
      end
   end

endmodule

// File: rtl/hc_stage.sv
module hc_stage
   import irq_agg_pkg::*;
#(
   parameter int DW      = 32,
   parameter int NUM_SER = 17,
   parameter int SER_TOP = 31,
   parameter int EN_BIT  = 31
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SER-1:0] ser_lines,
   input  logic               wr_en,
   input  reg_id_e            wr_id,
   input  logic [DW-1:0]      wdata,
   output logic [DW-1:0]      seg_q,
   output logic [DW-1:0]      rdsz_q,
   output logic [DW-1:0]      ctrl_q,
   output logic [DW-1:0]      mask_q,
   output logic [DW-1:0]      status_q,
   output logic               agg_out
);

   localparam int LOW_BIT = SER_TOP - NUM_SER + 1;

   if (LOW_BIT < 0) begin : g_bad_map
      $error("hc_stage: NUM_SER does not fit below SER_TOP");
   end
   if (SER_TOP >= DW || EN_BIT >= DW) begin : g_bad_bits
      $error("hc_stage: bit index beyond data width");
   end

   logic [DW-1:0] set_vec;
   logic          clr_we;

   always_comb begin
      set_vec = '0;
      for (int n = 0; n < NUM_SER; n++) begin
         set_vec[SER_TOP-n] = ser_lines[n];
      end
   end

   assign clr_we = wr_en && (wr_id == RID_STAT1);

   sticky_w1c_reg #(.W(DW), .SET_WINS(1'b1)) u_stat (
      .clk     (clk),
      .rst     (rst),
      .set_vec (set_vec),
      .clr_we  (clr_we),
      .clr_vec (wdata),
      .q       (status_q)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         seg_q  <= '0;
         rdsz_q <= DW'(RDSZ_RESET);
         ctrl_q <= '0;
         mask_q <= '0;
      end else if (wr_en) begin
         case (wr_id)
            RID_SEG:   seg_q  <= wdata;
            RID_RDSZ:  rdsz_q <= wdata;
            RID_CTRL:  ctrl_q <= wdata;
            RID_MASK1: mask_q <= wdata;
            default:   ;
         endcase
      end
   end

   assign agg_out = ctrl_q[EN_BIT] && ((status_q & mask_q) != '0);

   AST_S1_STICKY: assert property (@(posedge clk) disable iff (rst)
      !clr_we |=> (($past(status_q) & ~status_q) == '0)); // R2

   AST_S1_SET: assert property (@(posedge clk) disable iff (rst)
      (set_vec != '0) |=> (($past(set_vec) & ~status_q) == '0)); // R3

   AST_S1_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (clr_we && set_vec == '0) |=> ((status_q & $past(wdata)) == '0)); // R3

endmodule

// File: rtl/master_stage.sv
module master_stage
   import irq_agg_pkg::*;
#(
   parameter int DW      = 32,
   parameter int SRC_BIT = 11
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          src_in,
   input  logic          wr_en,
   input  reg_id_e       wr_id,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] route0_q,
   output logic [DW-1:0] route1_q,
   output logic [DW-1:0] pol_q,
   output logic [DW-1:0] mask_q,
   output logic [DW-1:0] status_q,
   output logic [DW-1:0] in_vec,
   output logic          irq_out
);

   if (SRC_BIT >= DW) begin : g_bad_src
      $error("master_stage: SRC_BIT beyond data width");
   end

   logic [DW-1:0] latch_vec;
   logic          clr_we;

   always_comb begin
      in_vec          = '0;
      in_vec[SRC_BIT] = src_in;
   end

   assign latch_vec = in_vec & mask_q;
   assign clr_we    = wr_en && (wr_id == RID_STAT2);

   sticky_w1c_reg #(.W(DW), .SET_WINS(1'b1)) u_stat (
      .clk     (clk),
      .rst     (rst),
      .set_vec (latch_vec),
      .clr_we  (clr_we),
      .clr_vec (wdata),
      .q       (status_q)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         route0_q <= '0;
         route1_q <= '0;
         pol_q    <= '0;
         mask_q   <= '0;
      end else if (wr_en) begin
         case (wr_id)
            RID_ROUTE0: route0_q <= wdata;
            RID_ROUTE1: route1_q <= wdata;
            RID_POL:    pol_q    <= wdata;
            RID_MASK2:  mask_q   <= wdata;
            default:    ;
         endcase
      end
   end

   assign irq_out = (status_q != '0);

   AST_S2_STICKY: assert property (@(posedge clk) disable iff (rst)
      !clr_we |=> (($past(status_q) & ~status_q) == '0)); // R5

   AST_S2_LATCH: assert property (@(posedge clk) disable iff (rst)
      (latch_vec != '0) |=> ((status_q & $past(latch_vec)) == $past(latch_vec))); // R5

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      (irq_out && !clr_we) |=> irq_out); // R6

endmodule

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg
   import irq_agg_pkg::*;
#(
   parameter int DW      = 32,
   parameter int AW      = 8,
   parameter int NUM_SER = 17,
   parameter int SER_TOP = 31,
   parameter int EN_BIT  = 31,
   parameter int SRC_BIT = 11
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SER-1:0] ser_irq,
   input  logic               wr_en,
   input  logic [AW-1:0]      addr,
   input  logic [DW-1:0]      wdata,
   output logic [DW-1:0]      rdata,
   output logic               irq_out
);

   if (AW < 7) begin : g_bad_aw
      $error("irq_cascade_agg: AW too small for the register map");
   end
   if (DW < 32) begin : g_bad_dw
      $error("irq_cascade_agg: DW must be at least 32");
   end

   reg_id_e       rid;
   logic [DW-1:0] seg_q, rdsz_q, ctrl_q, mask1_q, stat1_q;
   logic [DW-1:0] route0_q, route1_q, pol_q, mask2_q, stat2_q, in2_vec;
   logic          stage1_out;

   always_comb begin
      case (addr)
         AW'(OFS_SEG):    rid = RID_SEG;
         AW'(OFS_RDSZ):   rid = RID_RDSZ;
         AW'(OFS_CTRL):   rid = RID_CTRL;
         AW'(OFS_MASK1):  rid = RID_MASK1;
         AW'(OFS_STAT1):  rid = RID_STAT1;
         AW'(OFS_ERRA):   rid = RID_ERRA;
         AW'(OFS_ROUTE0): rid = RID_ROUTE0;
         AW'(OFS_ROUTE1): rid = RID_ROUTE1;
         AW'(OFS_STAT2):  rid = RID_STAT2;
         AW'(OFS_MASK2):  rid = RID_MASK2;
         AW'(OFS_POL):    rid = RID_POL;
         AW'(OFS_INPUT):  rid = RID_INPUT;
         default:         rid = RID_NONE;
      endcase
   end

   hc_stage #(
      .DW(DW), .NUM_SER(NUM_SER), .SER_TOP(SER_TOP), .EN_BIT(EN_BIT)
   ) u_hc (
      .clk       (clk),
      .rst       (rst),
      .ser_lines (ser_irq),
      .wr_en     (wr_en),
      .wr_id     (rid),
      .wdata     (wdata),
      .seg_q     (seg_q),
      .rdsz_q    (rdsz_q),
      .ctrl_q    (ctrl_q),
      .mask_q    (mask1_q),
      .status_q  (stat1_q),
      .agg_out   (stage1_out)
   );

   master_stage #(.DW(DW), .SRC_BIT(SRC_BIT)) u_master (
      .clk      (clk),
      .rst      (rst),
      .src_in   (stage1_out),
      .wr_en    (wr_en),
      .wr_id    (rid),
      .wdata    (wdata),
      .route0_q (route0_q),
      .route1_q (route1_q),
      .pol_q    (pol_q),
      .mask_q   (mask2_q),
      .status_q (stat2_q),
      .in_vec   (in2_vec),
      .irq_out  (irq_out)
   );

   always_comb begin
      case (rid)
         RID_SEG:    rdata = seg_q;
         RID_RDSZ:   rdata = rdsz_q;
         RID_CTRL:   rdata = ctrl_q;
         RID_MASK1:  rdata = mask1_q;
         RID_STAT1:  rdata = stat1_q;
         RID_ERRA:   rdata = '0;
         RID_ROUTE0: rdata = route0_q;
         RID_ROUTE1: rdata = route1_q;
         RID_STAT2:  rdata = stat2_q;
         RID_MASK2:  rdata = mask2_q;
         RID_POL:    rdata = pol_q;
         RID_INPUT:  rdata = in2_vec;
         default:    rdata = '1;
      endcase
   end

   AST_EN_GATE: assert property (@(posedge clk) disable iff (rst)
      !ctrl_q[EN_BIT] |-> !in2_vec[SRC_BIT]); // R4

   AST_OUT_ROSE: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_out) |-> $past(in2_vec[SRC_BIT] && mask2_q[SRC_BIT])); // R9

endmodule

// File: tb/irq_cascade_agg_test.sv
module irq_cascade_agg_test;

   logic        clk = 1'b0;
   logic        rst;
   logic [16:0] ser_irq;
   logic        wr_en;
   logic [7:0]  addr;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic        irq_out;

   int total = 0;
   int bad   = 0;
   logic probe = 1'b0;
   bit   finished = 1'b0;

   typedef struct {
      logic [31:0] exp_d;
      bit          use_d;
      logic        exp_irq;
      string       tag;
   } item_t;

   item_t sb[$];

   always #4 clk = ~clk;

   irq_cascade_agg uut (
      .clk(clk), .rst(rst), .ser_irq(ser_irq), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
   );

   // monitor: compares one scoreboard item per probed cycle
   always @(negedge clk) begin
      if (probe && sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         total++;
         if ((it.use_d && rdata !== it.exp_d) || irq_out !== it.exp_irq) begin
            bad++;
            $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                     it.tag, rdata, irq_out, it.exp_d, it.exp_irq);
         end
      end
   end

   task automatic chk(input logic [7:0] a, input logic [31:0] d, input bit use_d,
                      input logic irq, input string tag);
      item_t it;
      it.exp_d = d; it.use_d = use_d; it.exp_irq = irq; it.tag = tag;
      addr = a;
      sb.push_back(it);
      probe = 1'b1;
      @(posedge clk); #1;
      probe = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic idle();
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; ser_irq = '0; wr_en = 1'b0; addr = '0; wdata = '0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;

      // R1 reset state
      chk(8'h04, 32'h0200_0000, 1, 0, "R1 fw read size reset");
      chk(8'h10, 32'h0, 1, 0, "R1 status1 reset");
      chk(8'h48, 32'h0, 1, 0, "R1 status2 reset");
      chk(8'h08, 32'h0, 1, 0, "R1 control reset");
      // R8 unimplemented offsets
      chk(8'h20, 32'hFFFF_FFFF, 1, 0, "R8 hole 0x20");
      chk(8'h7C, 32'hFFFF_FFFF, 1, 0, "R8 hole 0x7C");

      // R2 mapping and stickiness: lines 0,5,16 pulse one cycle
      ser_irq = 17'h10021;
      idle();
      ser_irq = '0;
      idle();
      chk(8'h10, 32'h8400_8000, 1, 0, "R2 reversed map sticky");

      // R4 enable off gates the first stage
      wr(8'h0C, 32'hFFFF_FFFF);
      chk(8'h54, 32'h0, 1, 0, "R4 gated by enable");
      wr(8'h0C, 32'h8000_0000);
      wr(8'h08, 32'h8000_0000);
      chk(8'h54, 32'h0000_0800, 1, 0, "R4 input bit 11");
      chk(8'h48, 32'h0, 1, 0, "R5 mask2 zero blocks latch");

      // R5 / R6 second stage latch
      wr(8'h4C, 32'h0000_0800);
      idle();
      chk(8'h48, 32'h0000_0800, 1, 1, "R6 status2 latched irq high");

      // R3 partial W1C; R5 stickiness after input drops
      wr(8'h10, 32'h8000_0000);
      chk(8'h10, 32'h0400_8000, 1, 1, "R3 only written bit cleared");
      chk(8'h54, 32'h0, 1, 1, "R4 input falls after clear");
      chk(8'h48, 32'h0000_0800, 1, 1, "R5 status2 sticky");
      wr(8'h48, 32'h0000_0800);
      chk(8'h48, 32'h0, 1, 0, "R5 status2 w1c");

      // R7 polarity/routes stored, no effect
      wr(8'h50, 32'hFFFF_FFFF);
      chk(8'h50, 32'hFFFF_FFFF, 1, 0, "R7 polarity readback");
      wr(8'h40, 32'hA5A5_5A5A);
      wr(8'h44, 32'h1234_5678);
      chk(8'h40, 32'hA5A5_5A5A, 1, 0, "R7 route0 readback");
      chk(8'h44, 32'h1234_5678, 1, 0, "R7 route1 readback");
      wr(8'h0C, 32'h0400_0000);
      idle();
      chk(8'h48, 32'h0000_0800, 1, 1, "R7 polarity ignored irq high");
      wr(8'h0C, 32'h0);
      wr(8'h48, 32'h0000_0800);
      chk(8'h48, 32'h0, 1, 0, "R6 irq low after clear");

      // R8 ignored writes; plain stored registers
      wr(8'h14, 32'h1234_5678);
      chk(8'h14, 32'h0, 1, 0, "R8 error address write ignored");
      wr(8'h54, 32'hFFFF_FFFF);
      chk(8'h54, 32'h0, 1, 0, "R8 input write ignored");
      wr(8'h00, 32'h0000_0003);
      chk(8'h00, 32'h0000_0003, 1, 0, "R1 segment select readback");
      wr(8'h04, 32'h0100_0000);
      chk(8'h04, 32'h0100_0000, 1, 0, "R1 read size readback");

      // R9 latency
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h0C, 32'hFFFF_8000);
      chk(8'h10, 32'h0, 1, 0, "R3 full clear");
      ser_irq[3] = 1'b1;
      chk(8'h10, 32'h0, 1, 0, "R9 before first edge");
      ser_irq[3] = 1'b0;
      chk(8'h10, 32'h1000_0000, 1, 0, "R9 status1 set irq still low");
      chk(8'h54, 32'h0000_0800, 1, 1, "R9 irq one cycle later");

      // R3 set wins over clear in the same cycle
      ser_irq[4] = 1'b1;
      wr(8'h10, 32'hFFFF_FFFF);
      ser_irq[4] = 1'b0;
      chk(8'h10, 32'h0800_0000, 1, 1, "R3 set beats clear");

      // R4 disable, then clear stage two
      wr(8'h08, 32'h0);
      wr(8'h48, 32'h0000_0800);
      chk(8'h54, 32'h0, 1, 0, "R4 disabled input zero");
      chk(8'h48, 32'h0, 1, 0, "R6 irq low disabled");
      chk(8'h10, 32'h0800_0000, 1, 0, "R2 status1 kept while disabled");

      idle();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule